// File: doc/BRIEF.md
# DDR Even/Odd Split Serializer

This block converts an 8-bit parallel word into a serial stream that carries two bits per clock period. A word presented with a load strobe is captured on a rising clock edge. The even-indexed bits go into one 4-bit shift register and the odd-indexed bits go into a second one.

The output is a multiplexer selected by the clock level. While the clock is high it shows the head of the even register. While the clock is low it shows the head of the odd register. Both registers advance together on every rising edge, so each even bit stays paired with the odd bit that follows it on the wire.

A word takes four clock periods to leave. The bits go out in the order bit 0, bit 1, up to bit 7. A new word is accepted on the edge that ends the previous one, so back-to-back words form a stream with no gap.

Top module: `ddr_split_ser`

## Requirements
- R1: While reset is asserted, and after it until a first word is accepted, the serial output is 0 in both clock phases.
- R2: With no word in progress, a load strobe sampled high on a rising edge captures `din`. Bit 0 is then shown in the high phase that follows that edge, and bit 1 in the next low phase.
- R3: On each of the three rising edges after the capture edge, the output advances by one pair. Over the four clock periods the output reads bits 0 through 7 in order, with even bits in high phases and odd bits in low phases.
- R4: A load strobe sampled on any of the three rising edges after a capture is ignored. The bits still to be sent are unchanged, whatever value `din` has.
- R5: A load strobe on the fourth rising edge after a capture is accepted, so bit 0 of the new word directly follows bit 7 of the previous word.
- R6: When the fourth rising edge after a capture passes with no load strobe, the output returns to 0 in both phases until the next accepted load.
- R7: With the load strobe held high, a new word is taken every four clock periods. The value taken is the one `din` holds at that rising edge.
- R8: Asserting reset in the middle of a word discards the rest of that word and forces the output to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Serial clock; its level also selects which register drives the output |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Load strobe, sampled on rising edges |
| din | input | WORD_W (8) | Parallel word; bit 0 is sent first |
| dout | output | 1 | Double-data-rate serial output |

## Verification
The embedded properties assume that `load` and `din` change only away from the rising clock edge. They also assume that reset is released only in a low phase, so the sampled strobe is unambiguous.

The bench changes every input a few nanoseconds after the falling edge. It samples `dout` in the middle of each phase, so the level-selected multiplexer never changes at a sampling point.

Stimulus exercises strobes held high continuously, strobes in every cycle of a word, and a strobe on exactly the fourth edge. These cases exercise the accept/ignore boundary that the properties describe.

// File: rtl/ddr_split_ser.sv
module ddr_split_ser #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic              dout
);
  localparam int LANE_W = WORD_W / 2;
  localparam int CNT_W  = (LANE_W > 1) ? $clog2(LANE_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LANE_W - 1);

  logic [LANE_W-1:0] even_sr, odd_sr, even_in, odd_in;
  logic [CNT_W-1:0]  cnt;
  logic              active;
  logic              take;

  for (genvar i = 0; i < LANE_W; i++) begin : g_split
    assign even_in[i] = din[2*i];
    assign odd_in[i]  = din[2*i+1];
  end

  assign take = load && (!active || cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      even_sr <= '0;
      odd_sr  <= '0;
      cnt     <= '0;
      active  <= 1'b0;
    end else if (take) begin
      even_sr <= even_in;
      odd_sr  <= odd_in;
      cnt     <= '0;
      active  <= 1'b1;
    end else if (active) begin
      even_sr <= even_sr >> 1;
      odd_sr  <= odd_sr >> 1;
      if (cnt == LAST) begin
        active <= 1'b0;
        cnt    <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign dout = clk ? even_sr[0] : odd_sr[0];

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (even_sr == '0 && odd_sr == '0));

  // R2
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !active) |=> (active && even_sr[0] == $past(din[0]) && odd_sr[0] == $past(din[1])));

  // R4
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt != LAST) |=> (active && cnt == CNT_W'($past(cnt) + 1'b1)));

  // R5
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == LAST && load) |=> (active && cnt == '0));

  // R6
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt == LAST && !load) |=> !active);
endmodule

// File: tb/ddr_split_ser_tb.sv
module ddr_split_ser_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load = 1'b0;
  logic [7:0] din = '0;
  logic dout;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit q[$];
  bit exp_hi = 1'b0;
  bit exp_lo = 1'b0;

  always #4 clk = ~clk;

  ddr_split_ser #(.WORD_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .load(load), .din(din), .dout(dout)
  );

  // behavioural reference: queue of bits still to be shown
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
    end else begin
      if (q.size() >= 2) begin
        void'(q.pop_front());
        void'(q.pop_front());
      end
      if (q.size() == 0 && load)
        for (int b = 0; b < 8; b++) q.push_back(din[b]);
    end
    exp_hi = (q.size() >= 2) ? q[0] : 1'b0;
    exp_lo = (q.size() >= 2) ? q[1] : 1'b0;
  end

  task automatic check(input string req, input bit act, input bit exp, input string ph);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s phase at %0t: actual %b expected %b", req, ph, $time, act, exp);
    end
  endtask

  always begin
    @(posedge clk); #2;
    check(cur_req, dout, (rst_n ? exp_hi : 1'b0), "high");
    @(negedge clk); #2;
    check(cur_req, dout, (rst_n ? exp_lo : 1'b0), "low");
  end

  task automatic tick(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #3;
    end
  endtask

  task automatic send(input logic [7:0] w);
    load = 1'b1; din = w;
    tick();
    load = 1'b0; din = ~w;
  endtask

  initial begin
    fork
      begin
        #800000;
        fails++;
        $display("FAIL watchdog expired at %0t: actual hang expected finish", $time);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    // R1: reset state, load ignored while reset held
    cur_req = "R1";
    load = 1'b1; din = 8'hFF;
    tick(3);
    load = 1'b0;
    rst_n = 1'b1;
    tick(3);

    // R2 and R3: single word then drain (R6)
    cur_req = "R2";
    send(8'hB4);
    cur_req = "R3";
    tick(3);
    cur_req = "R6";
    tick(4);

    cur_req = "R3";
    send(8'h5A);
    tick(7);

    // R4: strobes on every busy edge with other data
    cur_req = "R4";
    load = 1'b1; din = 8'hA5;
    tick();
    din = 8'hFF; tick();
    din = 8'h00; tick();
    din = 8'h3C; tick();
    load = 1'b0;
    tick(5);

    // R5: strobe exactly on the fourth edge
    cur_req = "R5";
    send(8'h81);
    tick(3);
    send(8'h7E);
    tick(3);
    send(8'hC3);
    tick(3);
    cur_req = "R6";
    tick(5);

    // R7: strobe held high, data changing every cycle
    cur_req = "R7";
    load = 1'b1;
    for (int c = 0; c < 40; c++) begin
      din = 8'(c * 37 + 11);
      tick();
    end
    load = 1'b0;
    tick(6);

    // R8: reset in the middle of a word
    cur_req = "R8";
    send(8'hFF);
    tick();
    rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
    tick(5);

    cur_req = "R2";
    send(8'h96);
    tick(6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule